// File: doc/BRIEF.md
# Pipelined Eight-Point Scaled Forward DCT

This block computes a one-dimensional eight-point forward discrete cosine transform with the fast factorization that leaves a fixed scale factor on each output. It is fed with one vector of eight signed samples per clock. A fixed number of cycles later it returns eight scaled coefficients. The data passes through a butterfly network, then five constant multipliers, then a recombination network. There is no feedback anywhere, so the block takes a new vector on every cycle and never stalls.

Every constant multiplier is a sum of shifted copies of its operand, built from adders only. A parameter sets how many fractional bits the constants keep, so accuracy can be traded for logic. The per-index output scaling is not applied here; the quantizer that follows is expected to fold it in. A full 8x8 two-dimensional transform needs sixteen passes through this block: eight over rows and eight over columns, with a transpose store between them that is kept outside the block.

Top module: `dct8_aan`

## Requirements
- R1: Sample k (k = 0..7) enters on `in_x[9k+8:9k]` as signed two's complement. Output k appears on `out_ck`, with widths 12, 14, 13, 14, 12, 14, 13, 14 bits for k = 0..7 (106 bits in all) when IN_W = 9.
- R2: `out_valid` repeats `in_valid` exactly 6 clock cycles later. The coefficients of the vector taken with `in_valid` high are on the outputs in the same cycle that `out_valid` is high.
- R3: A new vector is accepted on every cycle. A burst of N back-to-back valid inputs produces N back-to-back valid outputs, and a cycle without input leaves a one-cycle gap at the output.
- R4: The outputs follow these fixed-point equations, written with s = x[k]+x[7-k] and d = x[k]-x[7-k]:
  - e10 = s0+s3, e13 = s0-s3, e11 = s1+s2, e12 = s1-s2
  - c0 = e10+e11, c4 = e10-e11
  - z1 = M(e12+e13, A), c2 = e13+z1, c6 = e13-z1
  - o10 = d3+d2, o11 = d2+d1, o12 = d1+d0
  - z5 = M(o10-o12, D), z2 = M(o10, B)+z5, z4 = M(o12, C)+z5, z3 = M(o11, A)
  - z11 = d0+z3, z13 = d0-z3
  - c1 = z11+z4, c7 = z11-z4, c5 = z13+z2, c3 = z13-z2
- R5: M(v, K) = floor(v·K / 2^FRAC). K is 0.707107, 0.541196, 1.306563 or 0.382683 (for A, B, C and D) times 2^FRAC, rounded to the nearest integer. With FRAC = 8 the integers are 181, 139, 334 and 98. The product is formed only by adding shifted copies of v. It is zero for v = 0, non-negative for v > 0 and negative for v < 0.
- R6: No intermediate value or output wraps, for any input combination, including every mix of -256 and +255 across the eight samples.
- R7: An input vector with all eight samples equal to v gives `out_c0` = 8v and zero on `out_c1` through `out_c7`.
- R8: While `rst` is high, `out_valid` is low from the next cycle on. A vector in flight when reset is asserted never produces a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_x` as a vector to transform |
| in_x | input | 72 | Eight packed signed samples, sample k at bits 9k+8:9k |
| out_valid | output | 1 | Marks the coefficient outputs as valid |
| out_c0 | output | 12 | Scaled coefficient 0 |
| out_c1 | output | 14 | Scaled coefficient 1 |
| out_c2 | output | 13 | Scaled coefficient 2 |
| out_c3 | output | 14 | Scaled coefficient 3 |
| out_c4 | output | 12 | Scaled coefficient 4 |
| out_c5 | output | 14 | Scaled coefficient 5 |
| out_c6 | output | 13 | Scaled coefficient 6 |
| out_c7 | output | 14 | Scaled coefficient 7 |

## Verification
A single nonzero sample placed on each lane in turn, at both extremes and small magnitudes, shows that the input packing and the output routing are correct and that no lane is swapped. A sweep of all 512 constant vectors confirms that every odd and even-difference path cancels exactly to zero, leaving only the DC term. All 256 mixes of -256 and +255 across the lanes drive every adder to its largest magnitude, which exposes any missing sign extension. A long pseudo-random stream with bubbles compares every coefficient against an arithmetic model of the rounding and flooring rules, and records input and output cycles to confirm the latency and the one-vector-per-cycle rate.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  // AAN rotation constants as reals; turned into integers per FRAC
  localparam real K_A = 0.707107;
  localparam real K_B = 0.541196;
  localparam real K_C = 1.306563;
  localparam real K_D = 0.382683;

  // nearest-integer fixed-point form of a positive constant
  function automatic int fix_const(real c, int frac);
    return int'(c * (2.0 ** frac));
  endfunction
endpackage

// File: rtl/dct8_cmul.sv
// Multiply by a positive constant using only shifted adds, then floor
module dct8_cmul #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 12,
  parameter int FRAC  = 8,
  parameter int KONST = 181
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] p
);
  localparam int PW = IN_W + FRAC + 2;
  localparam int NB = FRAC + 2;

  logic signed [PW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int b = 0; b < NB; b++) begin
      if (KONST[b]) acc = acc + (PW'(x) <<< b);
    end
    p = OUT_W'(acc >>> FRAC);
  end

  always_comb begin
    if (x == '0) begin
      AST_CMUL_ZERO: assert (p == '0); // R5
    end else if (x > 0) begin
      AST_CMUL_SIGN_POS: assert (p >= 0); // R5
    end else begin
      AST_CMUL_SIGN_NEG: assert (p < 0); // R5
    end
  end
endmodule

// File: rtl/dct8_vpipe.sv
// Valid-flag delay line matching the datapath depth
module dct8_vpipe #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DEPTH-2:0], d};
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/dct8_aan.sv
module dct8_aan
  import dct8_pkg::*;
#(
  parameter int IN_W = 9,
  parameter int FRAC = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [8*IN_W-1:0]        in_x,
  output logic                     out_valid,
  output logic signed [IN_W+2:0]   out_c0,
  output logic signed [IN_W+4:0]   out_c1,
  output logic signed [IN_W+3:0]   out_c2,
  output logic signed [IN_W+4:0]   out_c3,
  output logic signed [IN_W+2:0]   out_c4,
  output logic signed [IN_W+4:0]   out_c5,
  output logic signed [IN_W+3:0]   out_c6,
  output logic signed [IN_W+4:0]   out_c7
);
  localparam int W1 = IN_W + 1;
  localparam int W2 = IN_W + 2;
  localparam int W3 = IN_W + 3;
  localparam int W4 = IN_W + 4;
  localparam int W5 = IN_W + 5;
  localparam int LATENCY = 6;
  localparam int KA = fix_const(K_A, FRAC);
  localparam int KB = fix_const(K_B, FRAC);
  localparam int KC = fix_const(K_C, FRAC);
  localparam int KD = fix_const(K_D, FRAC);

  // stage 1: mirror butterflies
  logic signed [W1-1:0] a_s [4];
  logic signed [W1-1:0] a_d [4];

  for (genvar k = 0; k < 4; k++) begin : g_bfly
    logic signed [IN_W-1:0] lo, hi;
    assign lo = in_x[k*IN_W +: IN_W];
    assign hi = in_x[(7-k)*IN_W +: IN_W];
    always_ff @(posedge clk) begin
      a_s[k] <= W1'(lo) + W1'(hi);
      a_d[k] <= W1'(lo) - W1'(hi);
    end
  end

  // stage 2: second-level sums
  logic signed [W2-1:0] b_e10, b_e11, b_e12, b_e13, b_o10, b_o11, b_o12;
  logic signed [W1-1:0] b_t7;
  always_ff @(posedge clk) begin
    b_e10 <= W2'(a_s[0]) + W2'(a_s[3]);
    b_e13 <= W2'(a_s[0]) - W2'(a_s[3]);
    b_e11 <= W2'(a_s[1]) + W2'(a_s[2]);
    b_e12 <= W2'(a_s[1]) - W2'(a_s[2]);
    b_o10 <= W2'(a_d[3]) + W2'(a_d[2]);
    b_o11 <= W2'(a_d[2]) + W2'(a_d[1]);
    b_o12 <= W2'(a_d[1]) + W2'(a_d[0]);
    b_t7  <= a_d[0];
  end

  // stage 3: DC/Nyquist pair and multiplier operands
  logic signed [W3-1:0] c_y0, c_y4, c_rs, c_dd;
  logic signed [W2-1:0] c_e13, c_o10, c_o11, c_o12;
  logic signed [W1-1:0] c_t7;
  always_ff @(posedge clk) begin
    c_y0  <= W3'(b_e10) + W3'(b_e11);
    c_y4  <= W3'(b_e10) - W3'(b_e11);
    c_rs  <= W3'(b_e12) + W3'(b_e13);
    c_dd  <= W3'(b_o10) - W3'(b_o12);
    c_e13 <= b_e13;
    c_o10 <= b_o10;
    c_o11 <= b_o11;
    c_o12 <= b_o12;
    c_t7  <= b_t7;
  end

  // stage 4: five shift-add constant multipliers
  logic signed [W3-1:0] z1_w, z5_w, p2_w, p4_w, z3_w;
  dct8_cmul #(.IN_W(W3), .OUT_W(W3), .FRAC(FRAC), .KONST(KA)) u_m_z1 (.x(c_rs),  .p(z1_w));
  dct8_cmul #(.IN_W(W3), .OUT_W(W3), .FRAC(FRAC), .KONST(KD)) u_m_z5 (.x(c_dd),  .p(z5_w));
  dct8_cmul #(.IN_W(W2), .OUT_W(W3), .FRAC(FRAC), .KONST(KB)) u_m_p2 (.x(c_o10), .p(p2_w));
  dct8_cmul #(.IN_W(W2), .OUT_W(W3), .FRAC(FRAC), .KONST(KC)) u_m_p4 (.x(c_o12), .p(p4_w));
  dct8_cmul #(.IN_W(W2), .OUT_W(W3), .FRAC(FRAC), .KONST(KA)) u_m_z3 (.x(c_o11), .p(z3_w));

  logic signed [W3-1:0] m_z1, m_z5, m_p2, m_p4, m_z3, m_y0, m_y4;
  logic signed [W2-1:0] m_e13;
  logic signed [W1-1:0] m_t7;
  always_ff @(posedge clk) begin
    m_z1  <= z1_w;
    m_z5  <= z5_w;
    m_p2  <= p2_w;
    m_p4  <= p4_w;
    m_z3  <= z3_w;
    m_e13 <= c_e13;
    m_t7  <= c_t7;
    m_y0  <= c_y0;
    m_y4  <= c_y4;
  end

  // stage 5: first recombination level
  logic signed [W4-1:0] f_y2, f_y6, f_z2, f_z4, f_z11, f_z13;
  logic signed [W3-1:0] f_y0, f_y4;
  always_ff @(posedge clk) begin
    f_y2  <= W4'(m_e13) + W4'(m_z1);
    f_y6  <= W4'(m_e13) - W4'(m_z1);
    f_z2  <= W4'(m_p2) + W4'(m_z5);
    f_z4  <= W4'(m_p4) + W4'(m_z5);
    f_z11 <= W4'(m_t7) + W4'(m_z3);
    f_z13 <= W4'(m_t7) - W4'(m_z3);
    f_y0  <= m_y0;
    f_y4  <= m_y4;
  end

  // stage 6: registered outputs
  always_ff @(posedge clk) begin
    out_c0 <= f_y0;
    out_c4 <= f_y4;
    out_c2 <= f_y2;
    out_c6 <= f_y6;
    out_c1 <= W5'(f_z11) + W5'(f_z4);
    out_c7 <= W5'(f_z11) - W5'(f_z4);
    out_c5 <= W5'(f_z13) + W5'(f_z2);
    out_c3 <= W5'(f_z13) - W5'(f_z2);
  end

  dct8_vpipe #(.DEPTH(LATENCY)) u_vpipe (
    .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
  );

  // cycles since reset, saturating, to bound the history used below
  localparam int CW = $clog2(LATENCY + 1);
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(LATENCY)) since_rst <= since_rst + 1'b1;
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CW'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY))); // R2
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R8
endmodule

// File: tb/dct8_aan_test.sv
`timescale 1ns/1ps
module dct8_aan_test;
  localparam int F = 8;
  localparam int NV = 4096;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [71:0] in_x = '0;
  logic out_valid;
  logic signed [11:0] c0, c4;
  logic signed [12:0] c2, c6;
  logic signed [13:0] c1, c3, c5, c7;

  always #4 clk = ~clk;

  dct8_aan #(.IN_W(9), .FRAC(F)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid),
    .out_c0(c0), .out_c1(c1), .out_c2(c2), .out_c3(c3),
    .out_c4(c4), .out_c5(c5), .out_c6(c6), .out_c7(c7)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;
  logic [71:0] vec [NV];
  int phase [NV];
  int in_cyc [NV];
  int out_cyc [NV];
  int wr = 0, rd = 0;
  int ka, kb, kc, kd;

  function automatic int mulc(int v, int k);
    return (v * k) >>> F;
  endfunction

  function automatic void model(input logic [71:0] v, output int y[8]);
    int x[8];
    int s[4], d[4];
    int e10, e11, e12, e13, o10, o11, o12, z1, z2, z3, z4, z5, z11, z13;
    for (int k = 0; k < 8; k++) x[k] = int'($signed(v[9*k +: 9]));
    for (int k = 0; k < 4; k++) begin
      s[k] = x[k] + x[7-k];
      d[k] = x[k] - x[7-k];
    end
    e10 = s[0] + s[3]; e13 = s[0] - s[3];
    e11 = s[1] + s[2]; e12 = s[1] - s[2];
    y[0] = e10 + e11;  y[4] = e10 - e11;
    z1 = mulc(e12 + e13, ka);
    y[2] = e13 + z1;   y[6] = e13 - z1;
    o10 = d[3] + d[2]; o11 = d[2] + d[1]; o12 = d[1] + d[0];
    z5 = mulc(o10 - o12, kd);
    z2 = mulc(o10, kb) + z5;
    z4 = mulc(o12, kc) + z5;
    z3 = mulc(o11, ka);
    z11 = d[0] + z3;   z13 = d[0] - z3;
    y[1] = z11 + z4;   y[7] = z11 - z4;
    y[5] = z13 + z2;   y[3] = z13 - z2;
  endfunction

  function automatic string tag(int p);
    case (p)
      1: return "R1";
      2: return "R7";
      3: return "R6";
      default: return "R4,R5";
    endcase
  endfunction

  task automatic check_out();
    int exp_y[8];
    int act[8];
    bit bad;
    act[0] = int'(c0); act[1] = int'(c1); act[2] = int'(c2); act[3] = int'(c3);
    act[4] = int'(c4); act[5] = int'(c5); act[6] = int'(c6); act[7] = int'(c7);
    if (rd >= wr) begin
      n_run++; n_fail++;
      $display("FAIL R2 unexpected out_valid at cycle %0d act=1 exp=0", cyc);
      return;
    end
    if (phase[rd] == 2) begin
      // R7: DC vector gives 8v on index 0, zero elsewhere
      for (int k = 0; k < 8; k++) exp_y[k] = 0;
      exp_y[0] = 8 * int'($signed(vec[rd][8:0]));
    end else begin
      model(vec[rd], exp_y);
    end
    bad = 0;
    for (int k = 0; k < 8; k++) if (act[k] != exp_y[k]) bad = 1;
    n_run++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s vec %0d act=%0d,%0d,%0d,%0d,%0d,%0d,%0d,%0d exp=%0d,%0d,%0d,%0d,%0d,%0d,%0d,%0d",
        tag(phase[rd]), rd, act[0], act[1], act[2], act[3], act[4], act[5], act[6], act[7],
        exp_y[0], exp_y[1], exp_y[2], exp_y[3], exp_y[4], exp_y[5], exp_y[6], exp_y[7]);
    end
    out_cyc[rd] = cyc;
    n_run++;
    if (cyc - in_cyc[rd] != LAT) begin
      n_fail++;
      $display("FAIL R2 latency vec %0d act=%0d exp=%0d", rd, cyc - in_cyc[rd], LAT);
    end
    rd++;
  endtask

  // one cycle: observe outputs, then present the next input
  task automatic step(input bit v, input logic [71:0] x, input int ph);
    @(negedge clk);
    cyc++;
    if (!rst && out_valid) check_out();
    in_valid = v;
    in_x = x;
    if (v) begin
      vec[wr] = x; phase[wr] = ph; in_cyc[wr] = cyc; wr++;
    end
  endtask

  function automatic logic [71:0] splat(int v);
    logic [71:0] r;
    for (int k = 0; k < 8; k++) r[9*k +: 9] = 9'(v);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int vals[6];
    logic [71:0] x;
    logic [31:0] lf;
    int first3, last3;
    ka = $rtoi(0.707107 * 256.0 + 0.5);
    kb = $rtoi(0.541196 * 256.0 + 0.5);
    kc = $rtoi(1.306563 * 256.0 + 0.5);
    kd = $rtoi(0.382683 * 256.0 + 0.5);
    vals = '{-256, -255, -1, 1, 128, 255};

    // R8: out_valid stays low during reset
    for (int i = 0; i < 4; i++) begin
      step(0, '0, 0);
      n_run++;
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R8 reset out_valid act=%0b exp=0", out_valid);
      end
    end
    @(negedge clk); rst = 0;

    // R1: single-lane impulses
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 6; j++) begin
        x = '0; x[9*k +: 9] = 9'(vals[j]);
        step(1, x, 1);
      end
    step(0, '0, 0);

    // R7: every constant vector
    for (int v = -256; v < 256; v++) step(1, splat(v), 2);
    step(0, '0, 0);

    // R6: all sign mixes at full scale, back to back
    first3 = wr;
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 8; k++) x[9*k +: 9] = m[k] ? 9'sd255 : -9'sd256;
      step(1, x, 3);
    end
    last3 = wr - 1;

    // R4, R5: pseudo-random stream with bubbles
    lf = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      x = {lf[8:0], lf[17:9], lf[26:18], lf[31:23], lf[12:4], lf[21:13], lf[30:22], lf[7:0], lf[31]};
      step(lf[3:0] != 4'd0, x, 4);
    end
    repeat (LAT + 2) step(0, '0, 0);

    // R3: the full-scale burst emerged on consecutive cycles
    n_run++;
    if (out_cyc[last3] - out_cyc[first3] != last3 - first3) begin
      n_fail++;
      $display("FAIL R3 burst span act=%0d exp=%0d", out_cyc[last3] - out_cyc[first3], last3 - first3);
    end
    n_run++;
    if (rd != wr) begin
      n_fail++;
      $display("FAIL R3 outputs act=%0d exp=%0d", rd, wr);
    end

    // R8: reset with vectors in flight flushes them
    for (int i = 0; i < 3; i++) step(1, splat(i + 5), 2);
    @(negedge clk); rst = 1; in_valid = 0;
    wr = rd;
    for (int i = 0; i < 3; i++) step(0, '0, 0);
    @(negedge clk); rst = 0;
    for (int i = 0; i < LAT + 3; i++) begin
      @(negedge clk);
      n_run++;
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R8 flushed vector act=%0b exp=0", out_valid);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule